// File: doc/BRIEF.md
# Serial Switch Register Access Master

This block lets on-chip logic read and write the 16-bit configuration registers of an external Ethernet switch over a three-wire serial link. The link has a chip select, a serial clock and one data line that both sides drive. The block drives the data line through an output enable. A host presents one request at a time with a direction flag, an 8-bit address and, for a write, 16 bits of data. The block builds the serial frame and shifts it out most significant bit first. For reads it releases the data line, collects the reply and returns one 16-bit register together with a one-cycle done pulse.

Reads and writes use different frames. A read starts with a long run of ones and keeps chip select low throughout. The reply carries 32 bits, which hold two neighbouring registers, and the address LSB selects which half is returned. A write is a short frame sent with chip select high. Both transactions end with extra clock pulses. Two parameters set the serial timing in system clock cycles: the clock half period and the data setup time. With these, one design meets the minimum edge timing at any system clock rate.

Top module: `swreg_serial_master`

## Requirements
- R1: Out of reset and whenever no transaction is in progress, chip select, serial clock, output enable, busy and done are all low.
- R2: A read sends 46 bits MSB first on the rising serial clock edges: 32 ones, then 0,1, then 1,0, then 0, then 0,0, then address bits 6 down to 0 (address bit 7 is not sent). Chip select stays low for the whole read.
- R3: After the 46th read bit's high phase the output enable drops and stays low until done. Two clock pulses follow, then 32 reply bits. Each reply bit is taken from the data input in the last system cycle before a rising serial clock edge, MSB first.
- R4: With done, rdata shows bits 31..16 of the reply when the read address is odd and bits 15..0 when it is even. It holds that value until the next read completes.
- R5: A read produces exactly 82 rising serial clock edges: 46 frame, 2 turnaround, 32 reply and 2 trailing.
- R6: A write sends 27 bits MSB first with chip select high on every rising edge: 1, then 0,1, then address bits 7..0, then data bits 15..0.
- R7: After the last write bit, the clock stays low for at least HALF_CYC cycles with chip select still high. Chip select then falls, and exactly 2 further rising edges follow with chip select low. A write has 29 rising edges in total, and the output enable stays high from the request until done.
- R8: Every serial clock high phase lasts exactly HALF_CYC system cycles. Every low phase between two rising edges lasts at least HALF_CYC+SETUP_CYC cycles. The data output changes only while the clock is low, and never within SETUP_CYC cycles before a rising edge.
- R9: Chip select is at its frame level at least HALF_CYC system cycles before the first rising edge of a frame.
- R10: Busy rises in the cycle after a request is accepted and falls in the cycle in which done is high. Done lasts one cycle. A request made while busy starts nothing and changes nothing in the running transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request strobe, accepted only while not busy |
| we | input | 1 | 1 selects write, 0 selects read |
| addr | input | 8 | Register address (bit 7 is unused for reads) |
| wdata | input | 16 | Data to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last read |
| sw_cs | output | 1 | Serial chip select |
| sw_clk | output | 1 | Serial clock |
| sw_dout | output | 1 | Serial data driven toward the switch |
| sw_oe | output | 1 | Output enable for the shared data line |
| sw_din | input | 1 | Serial data received from the switch |

## Verification
The embedded assertions check on every cycle that the link is quiet when idle, that chip select stays low through a read and during the trailing clocks of a write, and that the output enable is off during turnaround and reply. They also check that data holds steady while the clock is high, that the phase timer stays within its limit, and that done is a single-cycle pulse taken with busy low. Only the bench scenarios can show that the frame bits arrive in the right order, that edge counts and phase lengths match, and that the reply is sampled at the right moment and split by the address LSB. The scenarios also show that address bit 7 is dropped from read frames and that a request made while busy has no effect.

// File: rtl/swm_pkg.sv
// Package: shared frame constants, phase encodings and frame builders
// for the serial switch register access master.
// Assumes: read and write frames are both left-justified in one
// FRAME_W-bit shift register and shifted out MSB first.
package swm_pkg;

    localparam int unsigned PRE_BITS   = 32;   // leading ones of a read
    localparam int unsigned RD_BITS    = 46;   // full read frame
    localparam int unsigned WR_BITS    = 27;   // full write frame
    localparam int unsigned RX_BITS    = 32;   // reply length
    localparam int unsigned TURN_CLKS  = 2;    // idle pulses before reply
    localparam int unsigned TRAIL_CLKS = 2;    // pulses closing a transfer
    localparam int unsigned FRAME_W    = RD_BITS;
    localparam int unsigned CNT_BITS   = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CSU,
        PH_SEND,
        PH_TURN,
        PH_RECV,
        PH_GAP,
        PH_TRAIL,
        PH_TAIL
    } phase_e;

    typedef enum logic [1:0] {
        SUB_LOA,   // clock low, data held
        SUB_LOB,   // clock low, new data set up
        SUB_HI     // clock high
    } sub_e;

    // Read frame: ones, start 01, opcode 10, T=0, D=00, 7-bit address.
    function automatic logic [FRAME_W-1:0] rd_frame(input logic [6:0] a);
        return {{PRE_BITS{1'b1}}, 2'b01, 2'b10, 1'b0, 2'b00, a};
    endfunction

    // Write frame: start 1, opcode 01, 8-bit address, 16 data bits.
    function automatic logic [FRAME_W-1:0] wr_frame(input logic [7:0] a,
                                                    input logic [15:0] d);
        return {1'b1, 2'b01, a, d, {(FRAME_W - WR_BITS){1'b0}}};
    endfunction

endpackage

// File: rtl/swm_phase_timer.sv
// Module: swm_phase_timer
// Counts system cycles within one serial timing phase and flags the
// last cycle of it. The limit is HALF_CYC, or SETUP_CYC when the
// sequencer asks for the setup slice.
// Assumes: HALF_CYC >= 1 and SETUP_CYC >= 1; run low forces a restart.
module swm_phase_timer #(
    parameter int unsigned HALF_CYC  = 750,
    parameter int unsigned SETUP_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_setup,
    output logic expire
);
    localparam int unsigned MAX_LEN = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
    localparam int unsigned CW      = $clog2(MAX_LEN + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Select the length of the current phase.
    always_comb lim = use_setup ? CW'(SETUP_CYC) : CW'(HALF_CYC);

    assign expire = run && (cnt == lim - 1'b1);

    // Advance within the phase; restart on expiry or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || expire)   cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    // R8: a phase never runs past its programmed length.
    assert_timer_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < lim));

endmodule

// File: rtl/swm_shift_unit.sv
// Module: swm_shift_unit
// Holds the outgoing frame (MSB first) and gathers the reply bits.
// Assumes: load and shift_tx are never high together; cap_en is
// raised in the last low cycle before a rising serial clock edge.
module swm_shift_unit
    import swm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               shift_tx,
    input  logic               cap_en,
    input  logic               din,
    output logic               tx_msb,
    output logic [RX_BITS-1:0] rx_word
);
    logic [FRAME_W-1:0] tx_q;

    // Load a new frame or move the next bit to the top.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_q <= '0;
        else if (load)     tx_q <= frame_in;
        else if (shift_tx) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end

    // Clear on a new request, then gather reply bits MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_word <= '0;
        else if (load)   rx_word <= '0;
        else if (cap_en) rx_word <= {rx_word[RX_BITS-2:0], din};
    end

    assign tx_msb = tx_q[FRAME_W-1];

endmodule

// File: rtl/swm_seq.sv
// Module: swm_seq
// Transaction sequencer: walks through chip-select setup, frame send,
// turnaround, reply, gap and trailing clocks, and drives the link pins
// and host handshake. All pins are decoded from registered state.
// Assumes: the timer's expire marks the last cycle of each phase.
module swm_seq
    import swm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic               addr_lsb,
    input  logic               expire,
    input  logic               tx_msb,
    input  logic [RX_BITS-1:0] rx_word,
    output logic               run,
    output logic               use_setup,
    output logic               load,
    output logic               shift_tx,
    output logic               cap_en,
    output logic               cs,
    output logic               sclk,
    output logic               dout,
    output logic               oe,
    output logic               busy,
    output logic               done,
    output logic [15:0]        rdata
);
    phase_e              phase;
    sub_e                sub;
    logic [CNT_BITS-1:0] left;
    logic                is_wr;
    logic                odd;
    logic                slot;

    // Phases that are built from clock pulses.
    always_comb slot = (phase == PH_SEND) || (phase == PH_TURN) ||
                       (phase == PH_RECV) || (phase == PH_TRAIL);

    // Decode strobes and pins from the current state.
    always_comb begin
        run       = (phase != PH_IDLE);
        busy      = run;
        sclk      = slot && (sub == SUB_HI);
        use_setup = slot && (sub == SUB_LOB);
        load      = (phase == PH_IDLE) && req;
        shift_tx  = expire && (phase == PH_SEND) && (sub == SUB_LOA);
        cap_en    = expire && (phase == PH_RECV) && (sub == SUB_LOB);
    end

    // Main transaction state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            sub   <= SUB_LOA;
            left  <= '0;
            is_wr <= 1'b0;
            odd   <= 1'b0;
            cs    <= 1'b0;
            dout  <= 1'b0;
            oe    <= 1'b0;
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req) begin
                        phase <= PH_CSU;
                        sub   <= SUB_LOA;
                        cs    <= we;
                        oe    <= 1'b1;
                        is_wr <= we;
                        odd   <= addr_lsb;
                        dout  <= 1'b0;
                    end
                end
                PH_CSU: begin
                    if (expire) begin
                        phase <= PH_SEND;
                        sub   <= SUB_LOA;
                        left  <= is_wr ? CNT_BITS'(WR_BITS) : CNT_BITS'(RD_BITS);
                    end
                end
                PH_GAP: begin
                    if (expire) begin
                        phase <= PH_TRAIL;
                        sub   <= SUB_LOA;
                        left  <= CNT_BITS'(TRAIL_CLKS);
                        cs    <= 1'b0;
                    end
                end
                PH_TAIL: begin
                    if (expire) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                        oe    <= 1'b0;
                        if (!is_wr)
                            rdata <= odd ? rx_word[31:16] : rx_word[15:0];
                    end
                end
                default: begin
                    if (expire) begin
                        case (sub)
                            SUB_LOA: begin
                                sub <= SUB_LOB;
                                if (phase == PH_SEND) dout <= tx_msb;
                            end
                            SUB_LOB: sub <= SUB_HI;
                            default: begin
                                sub <= SUB_LOA;
                                if (left != CNT_BITS'(1)) begin
                                    left <= left - 1'b1;
                                end else begin
                                    case (phase)
                                        PH_SEND: begin
                                            dout <= 1'b0;
                                            if (is_wr) begin
                                                phase <= PH_GAP;
                                            end else begin
                                                phase <= PH_TURN;
                                                oe    <= 1'b0;
                                                left  <= CNT_BITS'(TURN_CLKS);
                                            end
                                        end
                                        PH_TURN: begin
                                            phase <= PH_RECV;
                                            left  <= CNT_BITS'(RX_BITS);
                                        end
                                        PH_RECV: phase <= PH_GAP;
                                        default: phase <= PH_TAIL;
                                    endcase
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // R2: chip select stays low through a read.
    assert_read_cs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_wr) |-> !cs);

    // R3: the data line is released during turnaround and reply.
    assert_turn_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_TURN) || (phase == PH_RECV)) |-> !oe);

    // R7: trailing clocks run with chip select low.
    assert_trail_cs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRAIL) |-> !cs);

    // R8: outgoing data holds while the serial clock is high.
    assert_dout_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(dout));

    // R10: done is a single pulse.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: busy is already low while done is shown.
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/swreg_serial_master.sv
// Module: swreg_serial_master (top)
// Reads and writes 16-bit switch registers over a chip-select, clock
// and shared data line. One request at a time; requests while busy
// are dropped. HALF_CYC and SETUP_CYC are in system clock cycles.
// Assumes: sw_din is already synchronous to clk.
module swreg_serial_master
    import swm_pkg::*;
#(
    parameter int unsigned HALF_CYC  = 750,
    parameter int unsigned SETUP_CYC = 250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [7:0]  addr,
    input  logic [15:0] wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        sw_cs,
    output logic        sw_clk,
    output logic        sw_dout,
    output logic        sw_oe,
    input  logic        sw_din
);
    logic               run;
    logic               use_setup;
    logic               expire;
    logic               load;
    logic               shift_tx;
    logic               cap_en;
    logic               tx_msb;
    logic [RX_BITS-1:0] rx_word;
    logic [FRAME_W-1:0] frame;

    // Build the frame for the request on the host inputs.
    always_comb frame = we ? wr_frame(addr, wdata) : rd_frame(addr[6:0]);

    swm_phase_timer #(
        .HALF_CYC  (HALF_CYC),
        .SETUP_CYC (SETUP_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .use_setup (use_setup),
        .expire    (expire)
    );

    swm_shift_unit u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .frame_in (frame),
        .shift_tx (shift_tx),
        .cap_en   (cap_en),
        .din      (sw_din),
        .tx_msb   (tx_msb),
        .rx_word  (rx_word)
    );

    swm_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .we        (we),
        .addr_lsb  (addr[0]),
        .expire    (expire),
        .tx_msb    (tx_msb),
        .rx_word   (rx_word),
        .run       (run),
        .use_setup (use_setup),
        .load      (load),
        .shift_tx  (shift_tx),
        .cap_en    (cap_en),
        .cs        (sw_cs),
        .sclk      (sw_clk),
        .dout      (sw_dout),
        .oe        (sw_oe),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata)
    );

    // R1: the link is quiet whenever no transaction runs.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sw_cs && !sw_clk && !sw_oe));

endmodule

// File: tb/swreg_serial_master_bench.sv
// Bench: a behavioural link monitor and switch-side model, checked on
// every clock (sampled on the falling system clock edge), plus
// directed read and write transactions.
module swreg_serial_master_bench;
    localparam int HALF  = 3;
    localparam int SETUP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [15:0] wdata = 16'h0000;
    logic        sdi = 1'b0;
    logic        busy, done, sw_cs, sw_clk, sw_dout, sw_oe;
    logic [15:0] rdata;

    int total = 0;
    int bad = 0;

    // 4 time units per period: 250 MHz at a 1 ns unit.
    always #2 clk = ~clk;

    swreg_serial_master #(.HALF_CYC(HALF), .SETUP_CYC(SETUP)) u_swreg_serial_master (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .rdata(rdata),
        .sw_cs(sw_cs), .sw_clk(sw_clk), .sw_dout(sw_dout), .sw_oe(sw_oe), .sw_din(sdi)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Monitor state
    logic p_clk = 0, p_cs = 0, p_dout = 0, p_done = 0, p_busy = 0;
    int   hi_cnt = 0, lo_cnt = 0, dout_age = 0, cs_age = 0;
    int   rises = 0, cs_fall_at = -1, done_cnt = 0;
    bit   cur_we = 0;
    logic [31:0] slave_word = 32'h0;
    bit   mon_bits[$];
    bit   mon_cs[$];

    // Per-cycle link model and rule checks.
    always @(negedge clk) begin
        if (!rst_n) begin
            p_clk = 0; p_cs = 0; p_dout = 0; p_done = 0; p_busy = 0;
            hi_cnt = 0; lo_cnt = 0; dout_age = 0; cs_age = 0;
        end else begin
            bit rise, fall;
            if (busy && !p_busy) begin
                rises = 0; cs_fall_at = -1; done_cnt = 0; cur_we = we;
                mon_bits.delete(); mon_cs.delete();
            end
            rise = sw_clk && !p_clk;
            fall = !sw_clk && p_clk;
            if (!busy)
                chk(!sw_cs && !sw_clk && !sw_oe, "R1", "idle pins cs/clk/oe",
                    {sw_cs, sw_clk, sw_oe}, 0);
            if (busy && cur_we) chk(sw_oe, "R7", "oe during write", sw_oe, 1);
            if (busy && !cur_we) chk(!sw_cs, "R2", "cs during read", sw_cs, 0);
            if (busy && !cur_we && (rises > 46 || (rises == 46 && !sw_clk)))
                chk(!sw_oe, "R3", "oe after read frame", sw_oe, 0);
            if (sw_clk && p_clk && (sw_dout != p_dout))
                chk(0, "R8", "dout changed while clock high", sw_dout, p_dout);
            if (sw_dout != p_dout) dout_age = 0; else dout_age++;
            if (sw_cs != p_cs) cs_age = 0; else cs_age++;
            if (fall) chk(hi_cnt == HALF, "R8", "high phase length", hi_cnt, HALF);
            if (rise) begin
                if (rises > 0)
                    chk(lo_cnt >= HALF + SETUP, "R8", "low phase length", lo_cnt, HALF + SETUP);
                else
                    chk(cs_age >= HALF, "R9", "cs lead before first edge", cs_age, HALF);
                if (sw_oe) chk(dout_age >= SETUP, "R8", "data setup", dout_age, SETUP);
                rises++;
                if (sw_oe) mon_bits.push_back(sw_dout);
                mon_cs.push_back(sw_cs);
            end
            if (rise) hi_cnt = 1; else if (sw_clk) hi_cnt++;
            if (rise) lo_cnt = 0; else if (fall) lo_cnt = 1; else if (!sw_clk) lo_cnt++;
            if (p_cs && !sw_cs && busy) begin
                cs_fall_at = rises;
                chk(!sw_clk && lo_cnt >= HALF, "R7", "clock low before cs drop", lo_cnt, HALF);
            end
            // Switch model: present the next reply bit after each falling edge.
            if (fall && !cur_we && rises >= 48 && rises < 80)
                sdi = slave_word[31 - (rises - 48)];
            if (done) begin
                done_cnt++;
                if (p_done) chk(0, "R10", "done longer than one cycle", 2, 1);
            end
            p_clk = sw_clk; p_cs = sw_cs; p_dout = sw_dout; p_done = done; p_busy = busy;
        end
    end

    task automatic run_txn(input bit w, input logic [7:0] a, input logic [15:0] d,
                           input logic [31:0] word, input bit poke);
        bit exp_bits[$];
        int n;
        bit seen;
        if (w) begin
            exp_bits.push_back(1); exp_bits.push_back(0); exp_bits.push_back(1);
            for (int i = 7; i >= 0; i--) exp_bits.push_back(a[i]);
            for (int i = 15; i >= 0; i--) exp_bits.push_back(d[i]);
        end else begin
            for (int i = 0; i < 32; i++) exp_bits.push_back(1);
            exp_bits.push_back(0); exp_bits.push_back(1);
            exp_bits.push_back(1); exp_bits.push_back(0);
            exp_bits.push_back(0); exp_bits.push_back(0); exp_bits.push_back(0);
            for (int i = 6; i >= 0; i--) exp_bits.push_back(a[i]);
        end
        @(negedge clk);
        slave_word = word;
        req = 1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 0;
        chk(busy, "R10", "busy after accept", busy, 1);
        if (poke) begin
            repeat (100) @(negedge clk);
            req = 1; we = ~w; addr = ~a;
            @(negedge clk);
            req = 0; we = w; addr = a;
        end
        seen = 0;
        for (int c = 0; c < 5000 && !seen; c++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(seen, "R10", "done seen", seen, 1);
        chk(!busy, "R10", "busy low with done", busy, 0);
        n = w ? 27 : 46;
        chk(mon_bits.size() == (w ? 29 : 46), w ? "R6" : "R2", "driven bit count",
            mon_bits.size(), w ? 29 : 46);
        if (mon_bits.size() >= n) begin
            for (int i = 0; i < n; i++)
                if (mon_bits[i] != exp_bits[i])
                    chk(0, w ? "R6" : "R2", $sformatf("frame bit %0d", i), mon_bits[i], exp_bits[i]);
            total++;
        end
        if (w) begin
            chk(rises == 29, "R7", "write rising edges", rises, 29);
            chk(cs_fall_at == 27, "R7", "edges before cs drop", cs_fall_at, 27);
            for (int i = 0; i < mon_cs.size(); i++)
                if (mon_cs[i] != (i < 27))
                    chk(0, "R6", $sformatf("cs at edge %0d", i), mon_cs[i], i < 27);
        end else begin
            chk(rises == 82, "R5", "read rising edges", rises, 82);
            chk(rdata == (a[0] ? word[31:16] : word[15:0]), "R4", "read result",
                rdata, a[0] ? word[31:16] : word[15:0]);
        end
        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R10", "done pulses per request", done_cnt, 1);
        chk(!busy, "R10", "no transaction started by dropped request", busy, 0);
    endtask

    // Global watchdog: counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk({sw_cs, sw_clk, sw_oe, busy, done} == 5'b0, "R1", "pins during reset",
            {sw_cs, sw_clk, sw_oe, busy, done}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk({sw_cs, sw_clk, sw_oe, busy, done} == 5'b0, "R1", "pins after reset",
            {sw_cs, sw_clk, sw_oe, busy, done}, 0);
        // R4 odd address, R2 frame, R3 sampling
        run_txn(0, 8'h05, 16'h0000, 32'hA5C3_1E77, 0);
        // R4 even address
        run_txn(0, 8'h12, 16'h0000, 32'h0F0F_B24D, 0);
        // R2 address bit 7 not sent on reads
        run_txn(0, 8'h83, 16'h0000, 32'h1234_8001, 0);
        // R6 R7 writes
        run_txn(1, 8'hA7, 16'h5AF0, 32'h0, 0);
        run_txn(1, 8'h00, 16'hFFFF, 32'h0, 0);
        // R4 rdata kept across writes
        chk(rdata == 16'h1234, "R4", "rdata held after writes", rdata, 16'h1234);
        // R10 request while busy is dropped
        run_txn(0, 8'h40, 16'h0000, 32'hFFFF_0000, 1);
        run_txn(1, 8'h3C, 16'h8001, 32'h0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule